// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the reference and feedback inputs of a phase-frequency detector (PFD) and reports whether the loop is locked. In every PFD cycle it counts the system-clock ticks between the rising edge of one input and the rising edge of the other, whichever leads. It publishes that count with a one-cycle strobe. The count is then compared with one of two limits. The narrow acquire limit applies while the loop is unlocked. The wider release limit applies once lock is held, so phase error a little beyond the acquire limit does not make the flag chatter.

Lock needs a programmable run of consecutive good cycles, set by a 2-bit run-length field. A single cycle beyond the release limit clears the flag at once. A 1-bit window select chooses between a narrow and a wide pair of limits. The detector only works when the PFD period is longer than the release limit, so the block also times successive reference edges and pulses a fault output when the spacing is too short.

Top module: `pll_lock_detect`

## Requirements
- R1: On the clock edge at which the second of the two rising edges is detected, `meas_valid` pulses for one cycle and `phase_err` carries the number of clock edges since the first one was detected. This holds whichever input leads. Both edges on the same clock edge give 0.
- R2: The phase measurement saturates at 2^PHASE_W-1 and never wraps.
- R3: While unlocked, a measurement strictly below the acquire limit counts as good. `locked` rises on the clock edge after the strobe that completes the required run of consecutive good cycles.
- R4: `cnt_sel` selects the run length: 0 gives 5, 1 gives 16, 2 gives 64 and 3 gives 255 cycles.
- R5: While unlocked, any measurement at or above the acquire limit restarts the run from zero.
- R6: While locked, measurements up to and including the release limit keep `locked` high. A single measurement strictly above it clears `locked` on the clock edge after that strobe.
- R7: `win_sel`=0 uses the narrow pair (LOCK_TH_N, UNLOCK_TH_N) and `win_sel`=1 uses the wide pair (LOCK_TH_W, UNLOCK_TH_W). Each release limit is larger than its acquire limit.
- R8: `period_fault` pulses for one cycle on the clock edge that detects a reference rising edge whose spacing from the previous one, in clock edges, is at or below the current release limit. The first reference edge after reset is never flagged.
- R9: Synchronous active-high reset clears `locked`, `meas_valid`, `period_fault` and every run and timing counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to time the edges |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | PFD reference input, synchronous to clk |
| fb_in | input | 1 | PFD feedback input, synchronous to clk |
| win_sel | input | 1 | Limit pair select, 0 narrow, 1 wide |
| cnt_sel | input | 2 | Required good-cycle run length select |
| locked | output | 1 | Lock flag |
| meas_valid | output | 1 | One-cycle strobe per completed measurement |
| phase_err | output | PHASE_W | Measured edge separation in clock ticks |
| period_fault | output | 1 | Reference period too short for detection |

## Verification
The bench builds the block with PHASE_W=5 and PER_W=8, a narrow pair of 3/7 ticks and a wide pair of 6/12 ticks. The run lengths keep their defaults of 5 to 255. With these values, a sweep of edge separations from 0 to 33 ticks, with each input leading in turn under both windows, crosses every acquire and release boundary and also reaches saturation within a few thousand clocks. The full 255-cycle run length, the run restart and short reference periods can also be driven to completion, with expected results coming from an arithmetic model of the requirements.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_REF_LEAD = 2'd1,
        MS_FB_LEAD  = 2'd2
    } meas_state_e;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    function automatic int unsigned run_length(input logic [1:0] sel,
                                               input int unsigned n0,
                                               input int unsigned n1,
                                               input int unsigned n2,
                                               input int unsigned n3);
        case (sel)
            2'd0:    return n0;
            2'd1:    return n1;
            2'd2:    return n2;
            default: return n3;
        endcase
    endfunction

endpackage

// File: rtl/pll_ld_edges.sv
module pll_ld_edges
    import pll_ld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic       fb_in,
    output edge_pair_t edges
);
    localparam int NCH = 2;

    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise;

    assign lvl = {ref_in, fb_in};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b1;
            else     prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end

    assign edges.ref_rise = rise[1];
    assign edges.fb_rise  = rise[0];
endmodule

// File: rtl/pll_ld_phase_meter.sv
module pll_ld_phase_meter
    import pll_ld_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  edge_pair_t         edges,
    output logic               meas_vld,
    output logic [PHASE_W-1:0] meas_err
);
    localparam logic [PHASE_W-1:0] CMAX = '1;

    meas_state_e        st_q, st_d;
    logic [PHASE_W-1:0] cnt_q, cnt_d, inc;
    logic               vld_d;
    logic [PHASE_W-1:0] err_d;

    assign inc = (cnt_q == CMAX) ? CMAX : cnt_q + PHASE_W'(1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        vld_d = 1'b0;
        err_d = meas_err;
        case (st_q)
            MS_IDLE: begin
                if (edges.ref_rise && edges.fb_rise) begin
                    vld_d = 1'b1;
                    err_d = '0;
                end else if (edges.ref_rise) begin
                    st_d  = MS_REF_LEAD;
                    cnt_d = '0;
                end else if (edges.fb_rise) begin
                    st_d  = MS_FB_LEAD;
                    cnt_d = '0;
                end
            end
            MS_REF_LEAD: begin
                if (edges.fb_rise) begin
                    vld_d = 1'b1;
                    err_d = inc;
                    st_d  = MS_IDLE;
                end else begin
                    cnt_d = inc;
                end
            end
            MS_FB_LEAD: begin
                if (edges.ref_rise) begin
                    vld_d = 1'b1;
                    err_d = inc;
                    st_d  = MS_IDLE;
                end else begin
                    cnt_d = inc;
                end
            end
            default: st_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= MS_IDLE;
            cnt_q    <= '0;
            meas_vld <= 1'b0;
            meas_err <= '0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            meas_vld <= vld_d;
            meas_err <= err_d;
        end
    end

    // R1: a strobe always follows a detected rising edge
    p_strobe_after_edge_r1: assert property (@(posedge clk) disable iff (rst)
        meas_vld |-> $past(edges.ref_rise || edges.fb_rise));

    // R2: a saturated count stays saturated while waiting
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q != MS_IDLE && cnt_q == CMAX && !edges.ref_rise && !edges.fb_rise)
        |=> (cnt_q == CMAX));
endmodule

// File: rtl/pll_ld_period_mon.sv
module pll_ld_period_mon #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic [PER_W-1:0] limit,
    output logic             fault
);
    localparam logic [PER_W-1:0] PMAX = '1;

    logic             seen_q;
    logic [PER_W-1:0] cnt_q, spacing;

    assign spacing = (cnt_q == PMAX) ? PMAX : cnt_q + PER_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
            fault  <= 1'b0;
        end else if (ref_rise) begin
            seen_q <= 1'b1;
            cnt_q  <= '0;
            fault  <= seen_q && (spacing <= limit);
        end else begin
            cnt_q  <= spacing;
            fault  <= 1'b0;
        end
    end

    // R8: a fault is only raised on a reference edge
    p_fault_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(ref_rise));

    // R8: the first reference edge after reset is never flagged
    p_first_edge_clean_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(seen_q));
endmodule

// File: rtl/pll_ld_lock_fsm.sv
module pll_ld_lock_fsm
    import pll_ld_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int GOOD_W  = 8,
    parameter int RUN0    = 5,
    parameter int RUN1    = 16,
    parameter int RUN2    = 64,
    parameter int RUN3    = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               meas_vld,
    input  logic [PHASE_W-1:0] meas_err,
    input  logic [PHASE_W-1:0] acq_th,
    input  logic [PHASE_W-1:0] rel_th,
    input  logic [1:0]         cnt_sel,
    output logic               locked
);
    lock_state_e       st_q;
    logic [GOOD_W-1:0] good_q;
    logic [GOOD_W:0]   good_nx;
    logic [GOOD_W:0]   need;

    assign need    = (GOOD_W+1)'(run_length(cnt_sel, RUN0, RUN1, RUN2, RUN3));
    assign good_nx = {1'b0, good_q} + (GOOD_W+1)'(1);
    assign locked  = (st_q == LK_HELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_HUNT;
            good_q <= '0;
        end else if (meas_vld) begin
            if (st_q == LK_HUNT) begin
                if (meas_err < acq_th) begin
                    if (good_nx >= need) begin
                        st_q   <= LK_HELD;
                        good_q <= '0;
                    end else begin
                        good_q <= good_nx[GOOD_W-1:0];
                    end
                end else begin
                    good_q <= '0;
                end
            end else if (meas_err > rel_th) begin
                st_q   <= LK_HUNT;
                good_q <= '0;
            end
        end
    end

    // R3: lock is entered only on a good measurement
    p_rise_on_good_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_vld && (meas_err < acq_th)));

    // R5: a bad measurement while hunting restarts the run
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (!locked && meas_vld && meas_err >= acq_th) |=> (good_q == '0 && !locked));

    // R6: within the release limit the flag is kept
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && meas_vld && meas_err <= rel_th) |=> locked);

    // R6: one measurement beyond the release limit drops lock
    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && meas_vld && meas_err > rel_th) |=> !locked);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_ld_pkg::*;
#(
    parameter int PHASE_W     = 8,
    parameter int PER_W       = 12,
    parameter int GOOD_W      = 8,
    parameter int LOCK_TH_N   = 4,
    parameter int UNLOCK_TH_N = 10,
    parameter int LOCK_TH_W   = 8,
    parameter int UNLOCK_TH_W = 20,
    parameter int RUN0        = 5,
    parameter int RUN1        = 16,
    parameter int RUN2        = 64,
    parameter int RUN3        = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_in,
    input  logic               fb_in,
    input  logic               win_sel,
    input  logic [1:0]         cnt_sel,
    output logic               locked,
    output logic               meas_valid,
    output logic [PHASE_W-1:0] phase_err,
    output logic               period_fault
);
    localparam logic [PHASE_W-1:0] ACQ_N = PHASE_W'(LOCK_TH_N);
    localparam logic [PHASE_W-1:0] REL_N = PHASE_W'(UNLOCK_TH_N);
    localparam logic [PHASE_W-1:0] ACQ_W = PHASE_W'(LOCK_TH_W);
    localparam logic [PHASE_W-1:0] REL_W = PHASE_W'(UNLOCK_TH_W);

    edge_pair_t         edges;
    logic [PHASE_W-1:0] acq_th, rel_th;
    logic [PER_W-1:0]   per_limit;

    assign acq_th    = win_sel ? ACQ_W : ACQ_N;
    assign rel_th    = win_sel ? REL_W : REL_N;
    assign per_limit = PER_W'(rel_th);

    pll_ld_edges u_edges (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .edges  (edges)
    );

    pll_ld_phase_meter #(.PHASE_W(PHASE_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .edges    (edges),
        .meas_vld (meas_valid),
        .meas_err (phase_err)
    );

    pll_ld_period_mon #(.PER_W(PER_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (edges.ref_rise),
        .limit    (per_limit),
        .fault    (period_fault)
    );

    pll_ld_lock_fsm #(
        .PHASE_W (PHASE_W),
        .GOOD_W  (GOOD_W),
        .RUN0    (RUN0),
        .RUN1    (RUN1),
        .RUN2    (RUN2),
        .RUN3    (RUN3)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .meas_vld (meas_valid),
        .meas_err (phase_err),
        .acq_th   (acq_th),
        .rel_th   (rel_th),
        .cnt_sel  (cnt_sel),
        .locked   (locked)
    );

    // R9: reset leaves every output idle on the next cycle
    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) |-> (!locked && !meas_valid && !period_fault));
endmodule

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    localparam int PW   = 5;
    localparam int SMAX = (1 << PW) - 1;
    localparam int AN = 3, RN = 7, AW = 6, RW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, fb_in = 1'b0, win_sel = 1'b0;
    logic [1:0] cnt_sel = 2'd0;
    logic locked, meas_valid, period_fault;
    logic [PW-1:0] phase_err;

    int n_chk = 0, n_bad = 0;
    int n_strobe = 0, n_fault = 0, last_err = 0;
    int m_good = 0, tick = 0, last_ref = 0;
    bit m_locked = 0, have_ref = 0, done = 0;

    always #10 clk = ~clk;

    pll_lock_detect #(
        .PHASE_W(PW), .PER_W(8),
        .LOCK_TH_N(AN), .UNLOCK_TH_N(RN),
        .LOCK_TH_W(AW), .UNLOCK_TH_W(RW)
    ) u_pll_lock_detect (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .win_sel(win_sel), .cnt_sel(cnt_sel), .locked(locked),
        .meas_valid(meas_valid), .phase_err(phase_err),
        .period_fault(period_fault)
    );

    always @(posedge clk) begin
        #5;
        if (meas_valid) begin
            n_strobe++;
            last_err = int'(phase_err);
        end
        if (period_fault) n_fault++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int need_of(input int sel);
        case (sel)
            0: return 5;
            1: return 16;
            2: return 64;
            default: return 255;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_locked = 0; m_good = 0; have_ref = 0;
        tick = 0;
    endtask

    // one PFD cycle: leader at offset 0, trailer at offset d, p clocks long
    task automatic pfd_cycle(input bit fb_lead, input int d, input int p);
        int ref_off, fb_off, e, acq, rel, rt;
        bit exp_fault;
        ref_off = fb_lead ? d : 0;
        fb_off  = fb_lead ? 0 : d;
        e   = (d > SMAX) ? SMAX : d;
        acq = win_sel ? AW : AN;
        rel = win_sel ? RW : RN;
        rt  = tick + ref_off;
        exp_fault = have_ref && ((rt - last_ref) <= rel);
        have_ref = 1; last_ref = rt;
        n_strobe = 0; n_fault = 0;
        for (int k = 0; k < p; k++) begin
            @(negedge clk);
            ref_in = (k == ref_off);
            fb_in  = (k == fb_off);
        end
        tick += p;
        if (!m_locked) begin
            if (e < acq) begin
                m_good++;
                if (m_good >= need_of(int'(cnt_sel))) begin
                    m_locked = 1; m_good = 0;
                end
            end else m_good = 0;
        end else if (e > rel) m_locked = 0;
        chk(n_strobe == 1, "R1 strobe count", n_strobe, 1);
        chk(last_err == e, (d > SMAX) ? "R2 saturated error" : "R1 error value", last_err, e);
        chk(locked == m_locked, "R3/R5/R6/R7 lock flag", int'(locked), int'(m_locked));
        chk(n_fault == int'(exp_fault), "R8 period fault", n_fault, int'(exp_fault));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: outputs idle after reset
        chk(!locked, "R9 locked after reset", int'(locked), 0);
        chk(!meas_valid, "R9 strobe after reset", int'(meas_valid), 0);
        chk(!period_fault, "R9 fault after reset", int'(period_fault), 0);

        // sweep of separation, leader and window (R1 R2 R3 R6 R7 R8)
        for (int w = 0; w < 2; w++) begin
            win_sel = w[0];
            for (int d = 0; d <= SMAX + 2; d++)
                for (int l = 0; l < 2; l++)
                    pfd_cycle(l[0], d, (d + 4 > 16) ? d + 4 : 16);
        end

        // R8: short reference periods around the narrow release limit
        do_reset();
        win_sel = 1'b0; cnt_sel = 2'd0;
        pfd_cycle(0, 1, RN);
        pfd_cycle(0, 1, RN);
        pfd_cycle(0, 1, RN + 1);
        pfd_cycle(0, 1, 16);
        win_sel = 1'b1;
        pfd_cycle(0, 1, RW);
        pfd_cycle(0, 1, RW + 1);
        pfd_cycle(0, 1, 16);

        // R4: each run length, with R6 release boundary
        win_sel = 1'b0;
        for (int s = 0; s < 4; s++) begin
            do_reset();
            cnt_sel = s[1:0];
            for (int i = 0; i < need_of(s) - 1; i++) pfd_cycle(i[0], AN - 1, 16);
            chk(!locked, "R4 not yet locked", int'(locked), 0);
            pfd_cycle(0, AN - 1, 16);
            chk(locked, "R4 locked after run", int'(locked), 1);
            pfd_cycle(1, RN, 16);
            pfd_cycle(0, RN + 1, 16);
            chk(!locked, "R6 dropped beyond release", int'(locked), 0);
        end

        // R5: one boundary measurement restarts the run
        do_reset();
        cnt_sel = 2'd1;
        for (int i = 0; i < 15; i++) pfd_cycle(i[0], 0, 16);
        pfd_cycle(0, AN, 16);
        for (int i = 0; i < 15; i++) pfd_cycle(i[0], AN - 1, 16);
        chk(!locked, "R5 run restarted", int'(locked), 0);
        pfd_cycle(1, 1, 16);
        chk(locked, "R5 locked after fresh run", int'(locked), 1);

        // R7: the same error locks with the wide window only
        do_reset();
        cnt_sel = 2'd0; win_sel = 1'b0;
        for (int i = 0; i < 5; i++) pfd_cycle(0, AW - 1, 16);
        chk(!locked, "R7 narrow window rejects", int'(locked), 0);
        win_sel = 1'b1;
        for (int i = 0; i < 5; i++) pfd_cycle(1, AW - 1, 16);
        chk(locked, "R7 wide window accepts", int'(locked), 1);

        // R9: reset while locked clears the flag and the run
        do_reset();
        chk(!locked, "R9 reset clears lock", int'(locked), 0);
        for (int i = 0; i < 4; i++) pfd_cycle(0, 0, 16);
        chk(!locked, "R9 run cleared by reset", int'(locked), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule